// File: doc/BRIEF.md
# Rotary Encoder Settings Menu

This block turns one quadrature rotary knob with a built-in push switch into a four-entry settings menu. The two encoder lines and the switch are synchronised and filtered. Turning the knob through one full detent gives a single up or down step. How long the switch is held tells a short press from a long press.

A long press toggles edit mode. When edit mode is entered, the filter-mode entry is selected. While editing, a short press moves to the next entry, and each detent raises or lowers the selected value within its legal range. The display gets a blink enable so that it can flash the entry being edited. Outside edit mode the four values stay frozen. The allowed range of the averaging exponent shrinks as the output rate goes up. Any rate increase that would leave the exponent out of range pulls the exponent down in the same cycle.

The time constants are parameters in clock cycles, with defaults derived from the clock frequency: 1 ms filtering, a 1 s long press and a 0.5 s blink period.

Top module: `enc_menu_top`

## Requirements
- R1: After reset the outputs are all zero: filter 0, exponent 0, coupling 0, rate 0, edit 0, selection 0 and blink 0.
- R2: A press held for LONG_PRESS_CYC filtered cycles toggles edit mode exactly once per press. Entering edit mode sets the selection to 0.
- R3: A press released before LONG_PRESS_CYC cycles advances the selection while editing, in the order 0 filter, 1 exponent, 2 coupling, 3 rate, then back to 0. Outside edit mode it changes nothing.
- R4: With {A,B} read as a two-bit code (A is bit 1), the sequence 00,10,11,01,00 is one clockwise detent and raises the selected value by one. The reverse sequence 00,01,11,10,00 lowers it by one. Outside edit mode, rotation leaves all values unchanged. The filter value is 0 for averaging and 1 for the decimating FIR.
- R5: A move in which both lines change at once is ignored. A partial turn that returns to 00 produces no step.
- R6: Values stop at their bounds rather than wrapping: filter 0..1, coupling 0..2 (0 DC, 1 AC, 2 calibration), rate 0..2 (0 48 kHz, 1 96 kHz, 2 192 kHz).
- R7: The exponent k (ratio 2^k) never exceeds 5 minus the rate code, which gives ratios up to 32x, 16x and 8x.
- R8: A rate increase lowers the exponent to the new maximum in the same cycle if it would otherwise exceed that maximum.
- R9: Outside edit mode, blink is 0. In edit mode it starts low on entry and toggles every BLINK_HALF_CYC cycles.
- R10: A level on any input that lasts fewer than DEBOUNCE_CYC cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Encoder line A, raw |
| enc_b | input | 1 | Encoder line B, raw |
| btn_i | input | 1 | Push switch, raw; polarity set by BTN_ACTIVE_LOW |
| filt_mode_o | output | 1 | 0 averaging, 1 decimating FIR |
| avg_log2_o | output | 3 | Averaging exponent k, ratio 2^k |
| coupling_o | output | 2 | 0 DC, 1 AC, 2 calibration |
| rate_o | output | 2 | 0 48 kHz, 1 96 kHz, 2 192 kHz |
| edit_o | output | 1 | Edit mode active |
| sel_o | output | 2 | Selected entry |
| blink_o | output | 1 | Blink enable for the selected entry |

## Verification
The knob is driven with clean clockwise and counter-clockwise detents, partial turns that back out, and a simultaneous change of both lines, which separates real steps from non-steps. The switch gets a two-cycle glitch, short holds and long holds, which tells filtering, short presses and long presses apart. Rotating past every bound shows saturation rather than wrapping, and rate steps taken with the exponent at its ceiling expose the clamp. A behavioural model follows every clock and compares all outputs, including the blink phase.

// File: rtl/enc_menu_pkg.sv
package enc_menu_pkg;

   typedef enum logic [1:0] {
      SEL_FILT  = 2'd0,
      SEL_RATIO = 2'd1,
      SEL_COUP  = 2'd2,
      SEL_RATE  = 2'd3
   } sel_e;

   localparam int RATIO_LOG_TOP = 5;
   localparam int COUP_TOP      = 2;
   localparam int RATE_TOP      = 2;

   typedef struct packed {
      logic       filt;
      logic [2:0] ratio;
      logic [1:0] coup;
      logic [1:0] rate;
   } cfg_t;

   // Highest exponent allowed at a given rate code
   function automatic logic [2:0] ratio_cap(input logic [1:0] rate);
      return 3'(RATIO_LOG_TOP) - {1'b0, rate};
   endfunction

endpackage

// File: rtl/enc_debounce.sv
module enc_debounce #(
   parameter int W   = 1,
   parameter int CYC = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic          s1, s2, q;
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            q   <= 1'b0;
            cnt <= '0;
         end else begin
            s1 <= din[i];
            s2 <= s1;
            if (s2 == q) begin
               cnt <= '0;
            end else if (cnt == CW'(CYC - 1)) begin
               q   <= s2;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end

      assign dout[i] = q;
   end

endmodule

// File: rtl/enc_quad_dec.sv
module enc_quad_dec (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab,
   output logic       up_o,
   output logic       dn_o
);
   logic [1:0]        prev;
   logic signed [3:0] acc, acc_nx;
   logic              up_nx, dn_nx, valid;

   function automatic logic [1:0] fwd(input logic [1:0] s);
      case (s)
         2'b00:   return 2'b10;
         2'b10:   return 2'b11;
         2'b11:   return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [1:0] rev(input logic [1:0] s);
      case (s)
         2'b00:   return 2'b01;
         2'b01:   return 2'b11;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   always_comb begin
      acc_nx = acc;
      up_nx  = 1'b0;
      dn_nx  = 1'b0;
      valid  = 1'b0;
      if (ab != prev) begin
         if (ab == fwd(prev)) begin
            valid = 1'b1;
            if (acc != 4'sd4) acc_nx = acc + 4'sd1;
         end else if (ab == rev(prev)) begin
            valid = 1'b1;
            if (acc != -4'sd4) acc_nx = acc - 4'sd1;
         end
         if (ab == 2'b00) begin
            up_nx  = valid && (acc_nx == 4'sd4);
            dn_nx  = valid && (acc_nx == -4'sd4);
            acc_nx = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 2'b00;
         acc  <= '0;
         up_o <= 1'b0;
         dn_o <= 1'b0;
      end else begin
         prev <= ab;
         acc  <= acc_nx;
         up_o <= up_nx;
         dn_o <= dn_nx;
      end
   end

endmodule

// File: rtl/enc_press_timer.sv
module enc_press_timer #(
   parameter int LONG = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held,
   output logic long_o,
   output logic short_o
);
   localparam int CW = $clog2(LONG + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         long_o  <= 1'b0;
         short_o <= 1'b0;
      end else if (held) begin
         if (cnt != CW'(LONG)) cnt <= cnt + 1'b1;
         long_o  <= (cnt == CW'(LONG - 1));
         short_o <= 1'b0;
      end else begin
         short_o <= (cnt != '0) && (cnt < CW'(LONG));
         long_o  <= 1'b0;
         cnt     <= '0;
      end
   end

endmodule

// File: rtl/enc_menu_ctrl.sv
module enc_menu_ctrl
   import enc_menu_pkg::*;
#(
   parameter int BLINK_HALF = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_up,
   input  logic       step_dn,
   input  logic       press_long,
   input  logic       press_short,
   output cfg_t       cfg_o,
   output logic       edit_o,
   output sel_e       sel_o,
   output logic       blink_o
);
   localparam int BW = $clog2(BLINK_HALF);

   cfg_t          cfg_q, cfg_nx;
   logic          edit_q, edit_nx;
   sel_e          sel_q, sel_nx;
   logic [BW-1:0] bcnt;
   logic          phase;
   logic [1:0]    rate_up;

   assign rate_up = cfg_q.rate + 2'd1;

   always_comb begin
      cfg_nx  = cfg_q;
      edit_nx = edit_q;
      sel_nx  = sel_q;
      if (press_long) begin
         edit_nx = !edit_q;
         if (!edit_q) sel_nx = SEL_FILT;
      end else if (edit_q && press_short) begin
         sel_nx = sel_e'(sel_q + 2'd1);
      end else if (edit_q && (step_up || step_dn)) begin
         case (sel_q)
            SEL_FILT: cfg_nx.filt = step_up;
            SEL_RATIO: begin
               if (step_up && (cfg_q.ratio < ratio_cap(cfg_q.rate)))
                  cfg_nx.ratio = cfg_q.ratio + 3'd1;
               else if (step_dn && (cfg_q.ratio != 3'd0))
                  cfg_nx.ratio = cfg_q.ratio - 3'd1;
            end
            SEL_COUP: begin
               if (step_up && (cfg_q.coup < 2'(COUP_TOP)))
                  cfg_nx.coup = cfg_q.coup + 2'd1;
               else if (step_dn && (cfg_q.coup != 2'd0))
                  cfg_nx.coup = cfg_q.coup - 2'd1;
            end
            default: begin
               if (step_up && (cfg_q.rate < 2'(RATE_TOP))) begin
                  cfg_nx.rate = rate_up;
                  if (cfg_q.ratio > ratio_cap(rate_up))
                     cfg_nx.ratio = ratio_cap(rate_up);
               end else if (step_dn && (cfg_q.rate != 2'd0)) begin
                  cfg_nx.rate = cfg_q.rate - 2'd1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         edit_q <= 1'b0;
         sel_q  <= SEL_FILT;
      end else begin
         cfg_q  <= cfg_nx;
         edit_q <= edit_nx;
         sel_q  <= sel_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt  <= '0;
         phase <= 1'b0;
      end else if (!edit_q) begin
         bcnt  <= '0;
         phase <= 1'b0;
      end else if (bcnt == BW'(BLINK_HALF - 1)) begin
         bcnt  <= '0;
         phase <= !phase;
      end else begin
         bcnt <= bcnt + 1'b1;
      end
   end

   assign cfg_o   = cfg_q;
   assign edit_o  = edit_q;
   assign sel_o   = sel_q;
   assign blink_o = edit_q & phase;

endmodule

// File: rtl/enc_menu_top.sv
module enc_menu_top
   import enc_menu_pkg::*;
#(
   parameter int CLK_HZ         = 50_000_000,
   parameter int DEBOUNCE_CYC   = CLK_HZ / 1000,
   parameter int LONG_PRESS_CYC = CLK_HZ,
   parameter int BLINK_HALF_CYC = CLK_HZ / 4,
   parameter bit BTN_ACTIVE_LOW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enc_a,
   input  logic       enc_b,
   input  logic       btn_i,
   output logic       filt_mode_o,
   output logic [2:0] avg_log2_o,
   output logic [1:0] coupling_o,
   output logic [1:0] rate_o,
   output logic       edit_o,
   output logic [1:0] sel_o,
   output logic       blink_o
);
   if (DEBOUNCE_CYC < 2) begin : g_bad_db
      $error("DEBOUNCE_CYC must be at least 2");
   end
   if (LONG_PRESS_CYC <= DEBOUNCE_CYC) begin : g_bad_long
      $error("LONG_PRESS_CYC must exceed DEBOUNCE_CYC");
   end
   if (BLINK_HALF_CYC < 2) begin : g_bad_blink
      $error("BLINK_HALF_CYC must be at least 2");
   end

   logic       btn_lvl;
   logic [2:0] clean;
   logic       step_up, step_dn, press_long, press_short;
   cfg_t       cfg;
   sel_e       sel;

   if (BTN_ACTIVE_LOW) begin : g_btn_low
      assign btn_lvl = !btn_i;
   end else begin : g_btn_high
      assign btn_lvl = btn_i;
   end

   enc_debounce #(.W(3), .CYC(DEBOUNCE_CYC)) u_db (
      .clk(clk), .rst_n(rst_n),
      .din({btn_lvl, enc_a, enc_b}), .dout(clean)
   );

   enc_quad_dec u_quad (
      .clk(clk), .rst_n(rst_n), .ab(clean[1:0]),
      .up_o(step_up), .dn_o(step_dn)
   );

   enc_press_timer #(.LONG(LONG_PRESS_CYC)) u_press (
      .clk(clk), .rst_n(rst_n), .held(clean[2]),
      .long_o(press_long), .short_o(press_short)
   );

   enc_menu_ctrl #(.BLINK_HALF(BLINK_HALF_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .step_up(step_up), .step_dn(step_dn),
      .press_long(press_long), .press_short(press_short),
      .cfg_o(cfg), .edit_o(edit_o), .sel_o(sel), .blink_o(blink_o)
   );

   assign filt_mode_o = cfg.filt;
   assign avg_log2_o  = cfg.ratio;
   assign coupling_o  = cfg.coup;
   assign rate_o      = cfg.rate;
   assign sel_o       = sel;

endmodule

// File: rtl/enc_menu_chk.sv
module enc_menu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       press_long,
   input logic       press_short,
   input logic       edit_o,
   input logic [1:0] sel_o,
   input logic       blink_o,
   input logic       filt_mode_o,
   input logic [2:0] avg_log2_o,
   input logic [1:0] coupling_o,
   input logic [1:0] rate_o
);
   AST_LONG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      press_long |=> (edit_o != $past(edit_o))); // R2

   AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (press_short && edit_o && !press_long) |=> (sel_o == $past(sel_o) + 2'd1)); // R3

   AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !edit_o |=> $stable({filt_mode_o, avg_log2_o, coupling_o, rate_o})); // R4

   AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (coupling_o <= 2'd2) && (rate_o <= 2'd2)); // R6

   AST_RATIO_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, avg_log2_o} + {2'b00, rate_o}) <= 4'd5); // R7

   AST_RATE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_o > $past(rate_o)) |-> (avg_log2_o <= $past(avg_log2_o))); // R8

   AST_BLINK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edit_o) |-> !blink_o); // R9

endmodule

bind enc_menu_top enc_menu_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .press_long(press_long), .press_short(press_short),
   .edit_o(edit_o), .sel_o(sel_o), .blink_o(blink_o),
   .filt_mode_o(filt_mode_o), .avg_log2_o(avg_log2_o),
   .coupling_o(coupling_o), .rate_o(rate_o)
);

// File: tb/enc_menu_top_tb.sv
`timescale 1ns/1ps
module enc_menu_top_tb_top;
   localparam int DB = 4;
   localparam int LP = 40;
   localparam int BH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enc_a = 1'b0, enc_b = 1'b0, btn = 1'b0;
   logic       filt_mode_o, edit_o, blink_o;
   logic [2:0] avg_log2_o;
   logic [1:0] coupling_o, rate_o, sel_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   enc_menu_top #(.CLK_HZ(1000), .DEBOUNCE_CYC(DB), .LONG_PRESS_CYC(LP),
                  .BLINK_HALF_CYC(BH), .BTN_ACTIVE_LOW(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .btn_i(btn),
      .filt_mode_o(filt_mode_o), .avg_log2_o(avg_log2_o), .coupling_o(coupling_o),
      .rate_o(rate_o), .edit_o(edit_o), .sel_o(sel_o), .blink_o(blink_o)
   );

   // ---------------- behavioural reference ----------------
   int s1 [3] = '{0, 0, 0};
   int s2 [3] = '{0, 0, 0};
   int fq [3] = '{0, 0, 0};
   int fc [3] = '{0, 0, 0};
   int m_prev = 0, m_acc = 0, m_up = 0, m_dn = 0;
   int m_hold = 0, m_long = 0, m_short = 0;
   int m_filt = 0, m_ratio = 0, m_coup = 0, m_rate = 0;
   int m_edit = 0, m_sel = 0, m_bc = 0, m_ph = 0;

   function automatic int gpos(int code);
      case (code)
         0: return 0;
         2: return 1;
         3: return 2;
         default: return 3;
      endcase
   endfunction

   always @(posedge clk) begin
      int raw [3];
      int ab, d;
      raw[2] = btn; raw[1] = enc_a; raw[0] = enc_b;
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin s1[i] = 0; s2[i] = 0; fq[i] = 0; fc[i] = 0; end
         m_prev = 0; m_acc = 0; m_up = 0; m_dn = 0; m_hold = 0; m_long = 0; m_short = 0;
         m_filt = 0; m_ratio = 0; m_coup = 0; m_rate = 0; m_edit = 0; m_sel = 0;
         m_bc = 0; m_ph = 0;
      end else begin
         // blink phase from the mode held before this edge
         if (m_edit == 0) begin m_bc = 0; m_ph = 0; end
         else if (m_bc == BH - 1) begin m_bc = 0; m_ph = 1 - m_ph; end
         else m_bc++;
         // menu state
         if (m_long) begin
            if (m_edit == 0) m_sel = 0;
            m_edit = 1 - m_edit;
         end else if (m_edit && m_short) begin
            m_sel = (m_sel + 1) % 4;
         end else if (m_edit && (m_up || m_dn)) begin
            d = m_up ? 1 : -1;
            case (m_sel)
               0: m_filt = m_up ? 1 : 0;
               1: if (m_ratio + d >= 0 && m_ratio + d <= 5 - m_rate) m_ratio += d;
               2: if (m_coup + d >= 0 && m_coup + d <= 2) m_coup += d;
               default: if (m_rate + d >= 0 && m_rate + d <= 2) begin
                  m_rate += d;
                  if (m_ratio > 5 - m_rate) m_ratio = 5 - m_rate;
               end
            endcase
         end
         // detent recognition from filtered lines
         ab = fq[1] * 2 + fq[0];
         m_up = 0; m_dn = 0;
         if (ab != m_prev) begin
            d = (gpos(ab) - gpos(m_prev) + 4) % 4;
            if (d == 1 && m_acc < 4) m_acc++;
            if (d == 3 && m_acc > -4) m_acc--;
            if (ab == 0) begin
               m_up = (d == 1 && m_acc == 4);
               m_dn = (d == 3 && m_acc == -4);
               m_acc = 0;
            end
         end
         m_prev = ab;
         // press classification
         if (fq[2]) begin
            m_long = (m_hold == LP - 1);
            if (m_hold < LP) m_hold++;
            m_short = 0;
         end else begin
            m_short = (m_hold > 0 && m_hold < LP);
            m_long = 0;
            m_hold = 0;
         end
         // input filtering: change accepted after DB agreeing samples
         for (int i = 0; i < 3; i++) begin
            if (s2[i] == fq[i]) fc[i] = 0;
            else if (fc[i] == DB - 1) begin fq[i] = s2[i]; fc[i] = 0; end
            else fc[i]++;
            s2[i] = s1[i];
            s1[i] = raw[i];
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 filter vs model", filt_mode_o, m_filt);
         chk("R7 exponent vs model", avg_log2_o, m_ratio);
         chk("R6 coupling vs model", coupling_o, m_coup);
         chk("R6 rate vs model", rate_o, m_rate);
         chk("R2 edit vs model", edit_o, m_edit);
         chk("R3 selection vs model", sel_o, m_sel);
         chk("R9 blink vs model", blink_o, m_edit & m_ph);
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_ab(int code, int hold);
      enc_a = code[1]; enc_b = code[0];
      idle(hold);
   endtask

   task automatic turn(bit cw);
      if (cw) begin put_ab(2, 8); put_ab(3, 8); put_ab(1, 8); put_ab(0, 8); end
      else    begin put_ab(1, 8); put_ab(3, 8); put_ab(2, 8); put_ab(0, 8); end
      idle(12);
   endtask

   task automatic press(int hold);
      btn = 1'b1; idle(hold);
      btn = 1'b0; idle(14);
   endtask

   initial begin
      int tog;
      logic last;
      idle(3);
      chk("R1 reset filter", filt_mode_o, 0);
      chk("R1 reset exponent", avg_log2_o, 0);
      chk("R1 reset coupling", coupling_o, 0);
      chk("R1 reset rate", rate_o, 0);
      chk("R1 reset edit", edit_o, 0);
      chk("R1 reset blink", blink_o, 0);
      rst_n = 1'b1;
      idle(4);

      turn(1'b1);
      chk("R4 rotation outside edit ignored", filt_mode_o, 0);
      press(10);
      chk("R3 short press outside edit ignored", sel_o, 0);

      btn = 1'b1; idle(2); btn = 1'b0; idle(12);
      btn = 1'b1; idle(3); btn = 1'b0; idle(12);
      chk("R10 glitch on switch ignored", edit_o, 0);
      chk("R10 glitch gives no selection change", sel_o, 0);
      enc_a = 1'b1; idle(2); enc_a = 1'b0; idle(12);

      press(60);
      chk("R2 long press enters edit", edit_o, 1);
      chk("R2 entry selects filter", sel_o, 0);

      tog = 0; last = blink_o;
      for (int i = 0; i < 4 * BH; i++) begin
         @(negedge clk);
         if (blink_o != last) tog++;
         last = blink_o;
      end
      chk("R9 blink toggles per half period", tog, 4);

      turn(1'b1);
      chk("R4 cw sets FIR filter", filt_mode_o, 1);
      turn(1'b1);
      chk("R6 filter saturates high", filt_mode_o, 1);
      turn(1'b0);
      chk("R4 ccw back to averaging", filt_mode_o, 0);

      put_ab(2, 8); put_ab(3, 8); put_ab(2, 8); put_ab(0, 8); idle(12);
      chk("R5 partial turn gives no step", filt_mode_o, 0);
      put_ab(3, 8); put_ab(0, 8); idle(12);
      chk("R5 two-line jump ignored", filt_mode_o, 0);

      press(10);
      chk("R3 short press to exponent", sel_o, 1);
      for (int i = 0; i < 7; i++) turn(1'b1);
      chk("R7 exponent ceiling at 48 kHz", avg_log2_o, 5);

      press(10);
      chk("R3 short press to coupling", sel_o, 2);
      for (int i = 0; i < 3; i++) turn(1'b1);
      chk("R6 coupling saturates at calibration", coupling_o, 2);
      turn(1'b0);
      chk("R4 ccw coupling to AC", coupling_o, 1);

      press(10);
      chk("R3 short press to rate", sel_o, 3);
      turn(1'b1);
      chk("R6 rate to 96 kHz", rate_o, 1);
      chk("R8 exponent clamped to 4", avg_log2_o, 4);
      turn(1'b1);
      chk("R8 exponent clamped to 3", avg_log2_o, 3);
      turn(1'b1);
      chk("R6 rate saturates at 192 kHz", rate_o, 2);

      press(10);
      chk("R3 selection wraps to filter", sel_o, 0);
      press(10);
      turn(1'b1);
      chk("R7 exponent held at 3 for 192 kHz", avg_log2_o, 3);
      turn(1'b0);
      chk("R4 ccw exponent", avg_log2_o, 2);
      turn(1'b0); turn(1'b0); turn(1'b0);
      chk("R6 exponent saturates low", avg_log2_o, 0);
      turn(1'b1); turn(1'b1);

      press(60);
      chk("R2 long press leaves edit", edit_o, 0);
      chk("R9 blink off outside edit", blink_o, 0);
      turn(1'b0);
      chk("R4 frozen after leaving edit", avg_log2_o, 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R2 actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule